// File: doc/BRIEF.md
# Enable-Qualified Converter Sample Front End

This block sits between two high-speed converter input ports and one processing channel. Each port presents a signed two's-complement mantissa, an unsigned binary exponent and an enable line. A fixed-point converter leaves its exponent inputs at zero. Every port input is sampled on the rising edge of the one system clock, which also clocks the logic downstream. Two configuration inputs are registered inside the block. One picks the port that feeds the channel. The other picks one of four rules that decide on which clock edges a new sample is taken.

The four rules cover these uses:
- Level gating takes a sample on every edge where the enable is high.
- Falling-edge and rising-edge qualification each take one sample on the first clock edge after the enable changes. This lets two channels split one interleaved diversity stream, with one channel using each edge direction. It also lets the system clock run faster than the converter data rate.
- Blanking passes every cycle through but forces the sample to zero while the enable is low.

The block registers the chosen sample and raises a valid strobe for one cycle each time a sample is taken.

Top module: `adc_gate_front`

## Requirements
- R1: During a clock edge with `rst_n` low, `out_valid`, `out_mant` and `out_exp` are cleared to 0. The registered configuration returns to port A with mode 0, and the enable history is emptied.
- R2: `cfg_port_sel` = 0 selects port A and `cfg_port_sel` = 1 selects port B. An accepted sample appears on `out_mant`/`out_exp` bit for bit, mantissa to mantissa and exponent to exponent.
- R3: Mode 0 (level gating). For each clock edge where the selected enable is high, `out_valid` is 1 after that edge and the outputs carry the sample present at that edge. For each edge where the enable is low, `out_valid` is 0 after it.
- R4: Mode 1 (falling edge). A sample is accepted only at an edge where the selected enable is low and was high at the previous edge. Later low edges are not accepted.
- R5: Mode 2 (rising edge). A sample is accepted only at an edge where the selected enable is high and was low at the previous edge. Later high edges are not accepted.
- R6: Mode 3 (blanking). `out_valid` is 1 after every edge. The outputs carry the selected sample when its enable is high, and all-zero mantissa and exponent when it is low.
- R7: In modes 0, 1 and 2, `out_mant` and `out_exp` keep their last accepted value after any edge where no sample is accepted.
- R8: The enable, mantissa and exponent of the port that is not selected have no effect on the outputs.
- R9: A change on `cfg_port_sel` or `cfg_mode` is registered at the next edge, and the new setting governs the edges after that. The enable history is emptied when the change is registered, so no transition is accepted at the first edge under the new setting.
- R10: The outputs reflect the decision for a sample exactly one clock edge after that sample is present, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples all port inputs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_port_sel | input | 1 | Port choice: 0 = A, 1 = B |
| cfg_mode | input | 2 | Qualification rule: 0 level, 1 falling edge, 2 rising edge, 3 blanking |
| port_a_mant | input | MANT_W | Port A two's-complement mantissa |
| port_a_exp | input | EXP_W | Port A unsigned exponent |
| port_a_en | input | 1 | Port A enable |
| port_b_mant | input | MANT_W | Port B two's-complement mantissa |
| port_b_exp | input | EXP_W | Port B unsigned exponent |
| port_b_en | input | 1 | Port B enable |
| out_mant | output | MANT_W | Registered mantissa for the channel |
| out_exp | output | EXP_W | Registered exponent for the channel |
| out_valid | output | 1 | One-cycle strobe for each accepted sample |

## Verification
The bench builds the block with `MANT_W` = 5 and `EXP_W` = 2. This shrinks a sample to 7 bits, so for every combination of port and mode the bench walks all 128 mantissa/exponent codes on the selected port. Meanwhile it drives the bitwise complement, and its own enable pattern, on the other port. Two enable patterns run in turn, long runs and then isolated single-cycle pulses, so each rule meets repeated levels as well as back-to-back transitions. Directed sequences then exercise a configuration change that lines up with an enable transition, and a reset in the middle of traffic.

// File: rtl/fe_pkg.sv
// Package: shared encodings for the converter input front end.
// Assumes: the mode codes are also the values software writes to cfg_mode.
package fe_pkg;

    typedef enum logic [1:0] {
        MODE_LEVEL = 2'd0,  // accept while enable is high
        MODE_FALL  = 2'd1,  // accept once after enable falls
        MODE_RISE  = 2'd2,  // accept once after enable rises
        MODE_BLANK = 2'd3   // pass every cycle, zero while enable is low
    } gate_mode_e;

endpackage

// File: rtl/fe_port_mux.sv
// Module: fe_port_mux
// Picks one converter port (mantissa, exponent, enable) out of NUM_PORTS.
// Assumes: sel_i is below NUM_PORTS; purely combinational, AND-OR structure.
module fe_port_mux #(
    parameter int NUM_PORTS = 2,
    parameter int MANT_W    = 14,
    parameter int EXP_W     = 3,
    localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [MANT_W-1:0] mant_i [NUM_PORTS],
    input  logic [EXP_W-1:0]  exp_i  [NUM_PORTS],
    input  logic              en_i   [NUM_PORTS],
    output logic [MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              en_o
);

    logic [MANT_W-1:0] mant_term [NUM_PORTS];
    logic [EXP_W-1:0]  exp_term  [NUM_PORTS];
    logic              en_term   [NUM_PORTS];

    // Per-port gated terms: only the selected port contributes.
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_term
        logic hit;
        assign hit          = (sel_i == SEL_W'(g));
        assign mant_term[g] = hit ? mant_i[g] : '0;
        assign exp_term[g]  = hit ? exp_i[g]  : '0;
        assign en_term[g]   = hit & en_i[g];
    end

    // OR-reduce the gated terms into the selected port.
    always_comb begin
        mant_o = '0;
        exp_o  = '0;
        en_o   = 1'b0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            mant_o = mant_o | mant_term[k];
            exp_o  = exp_o  | exp_term[k];
            en_o   = en_o   | en_term[k];
        end
    end

endmodule

// File: rtl/fe_qualify.sv
// Module: fe_qualify
// Decides per clock whether the selected sample is taken, from the mode and
// a one-cycle history of the enable level.
// Assumes: clear_i is high on the edge where the configuration changes;
// history is invalid after reset or clear, so no edge is seen on the next edge.
module fe_qualify
    import fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  gate_mode_e mode_i,
    input  logic       clear_i,
    input  logic       en_i,
    output logic       take_o,
    output logic       blank_o
);

    logic en_prev_q;
    logic hist_vld_q;

    // Enable history: previous level and whether it belongs to this setting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_prev_q  <= 1'b0;
            hist_vld_q <= 1'b0;
        end else if (clear_i) begin
            en_prev_q  <= 1'b0;
            hist_vld_q <= 1'b0;
        end else begin
            en_prev_q  <= en_i;
            hist_vld_q <= 1'b1;
        end
    end

    // Acceptance rule per mode.
    always_comb begin
        take_o  = 1'b0;
        blank_o = 1'b0;
        unique case (mode_i)
            MODE_LEVEL: take_o = en_i;
            MODE_FALL:  take_o = hist_vld_q & en_prev_q & ~en_i;
            MODE_RISE:  take_o = hist_vld_q & ~en_prev_q & en_i;
            MODE_BLANK: begin
                take_o  = 1'b1;
                blank_o = ~en_i;
            end
            default:    take_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/fe_out_reg.sv
// Module: fe_out_reg
// Output register: loads the sample (or zero when blanked) on a take,
// holds otherwise; valid follows take one cycle later.
// Assumes: take_i and blank_i come from fe_qualify in the same cycle.
module fe_out_reg #(
    parameter int MANT_W = 14,
    parameter int EXP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_i,
    input  logic              blank_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [EXP_W-1:0]  exp_i,
    output logic [MANT_W-1:0] mant_o,
    output logic [EXP_W-1:0]  exp_o,
    output logic              valid_o
);

    // Load-or-hold data register with one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mant_o  <= '0;
            exp_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= take_i;
            if (take_i) begin
                mant_o <= blank_i ? '0 : mant_i;
                exp_o  <= blank_i ? '0 : exp_i;
            end
        end
    end

endmodule

// File: rtl/adc_gate_front.sv
// Module: adc_gate_front (top)
// Registers the port/mode configuration, selects one of two converter
// ports, qualifies samples by enable mode and registers the result.
// Assumes: one system clock; configuration inputs may change on any cycle
// and apply from the edge after they are registered.
module adc_gate_front
    import fe_pkg::*;
#(
    parameter int MANT_W = 14,
    parameter int EXP_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_port_sel,
    input  logic [1:0]        cfg_mode,
    input  logic [MANT_W-1:0] port_a_mant,
    input  logic [EXP_W-1:0]  port_a_exp,
    input  logic              port_a_en,
    input  logic [MANT_W-1:0] port_b_mant,
    input  logic [EXP_W-1:0]  port_b_exp,
    input  logic              port_b_en,
    output logic [MANT_W-1:0] out_mant,
    output logic [EXP_W-1:0]  out_exp,
    output logic              out_valid
);

    localparam int NUM_PORTS = 2;

    logic              sel_q;
    gate_mode_e        mode_q;
    logic              cfg_change;
    logic [MANT_W-1:0] mant_arr [NUM_PORTS];
    logic [EXP_W-1:0]  exp_arr  [NUM_PORTS];
    logic              en_arr   [NUM_PORTS];
    logic [MANT_W-1:0] sel_mant;
    logic [EXP_W-1:0]  sel_exp;
    logic              sel_en;
    logic              take;
    logic              blank;

    assign mant_arr[0] = port_a_mant;
    assign mant_arr[1] = port_b_mant;
    assign exp_arr[0]  = port_a_exp;
    assign exp_arr[1]  = port_b_exp;
    assign en_arr[0]   = port_a_en;
    assign en_arr[1]   = port_b_en;

    // Detect a pending configuration change.
    assign cfg_change = (cfg_port_sel != sel_q) || (cfg_mode != mode_q);

    // Configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            mode_q <= MODE_LEVEL;
        end else begin
            sel_q  <= cfg_port_sel;
            mode_q <= gate_mode_e'(cfg_mode);
        end
    end

    fe_port_mux #(
        .NUM_PORTS (NUM_PORTS),
        .MANT_W    (MANT_W),
        .EXP_W     (EXP_W)
    ) u_mux (
        .sel_i  (sel_q),
        .mant_i (mant_arr),
        .exp_i  (exp_arr),
        .en_i   (en_arr),
        .mant_o (sel_mant),
        .exp_o  (sel_exp),
        .en_o   (sel_en)
    );

    fe_qualify u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode_q),
        .clear_i (cfg_change),
        .en_i    (sel_en),
        .take_o  (take),
        .blank_o (blank)
    );

    fe_out_reg #(
        .MANT_W (MANT_W),
        .EXP_W  (EXP_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (take),
        .blank_i (blank),
        .mant_i  (sel_mant),
        .exp_i   (sel_exp),
        .mant_o  (out_mant),
        .exp_o   (out_exp),
        .valid_o (out_valid)
    );

endmodule

// File: rtl/fe_gate_checker.sv
// Module: fe_gate_checker
// Temporal properties of adc_gate_front, attached through bind.
// Assumes: mode_q and sel_en are the registered mode and selected enable.
module fe_gate_checker
    import fe_pkg::*;
#(
    parameter int MANT_W = 14,
    parameter int EXP_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_q,
    input logic              sel_en,
    input logic [MANT_W-1:0] out_mant,
    input logic [EXP_W-1:0]  out_exp,
    input logic              out_valid
);

    logic arm1_q;
    logic arm2_q;
    logic rst_seen_q;

    // Arming: two clean cycles after reset before history-based checks.
    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
        if (!rst_n) begin
            arm1_q <= 1'b0;
            arm2_q <= 1'b0;
        end else begin
            arm1_q <= 1'b1;
            arm2_q <= arm1_q;
        end
    end

    // R1: after a reset edge the outputs read zero.
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1) begin
            p_reset_clear_r1: assert (out_valid == 1'b0 && out_mant == '0 && out_exp == '0)
                else $error("p_reset_clear_r1");
        end
    end

    // R3: in level mode valid mirrors the enable of the previous edge.
    p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2_q && mode_q == MODE_LEVEL) |=> (out_valid == $past(sel_en)));

    // R4 R5: edge modes never accept on two consecutive edges.
    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2_q && (mode_q == MODE_FALL || mode_q == MODE_RISE) && out_valid) |=> !out_valid);

    // R6: blanking mode strobes every cycle.
    p_blank_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm1_q && mode_q == MODE_BLANK) |=> out_valid);

    // R6: blanking mode zeroes data while enable is low.
    p_blank_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (arm1_q && mode_q == MODE_BLANK && !sel_en) |=> (out_mant == '0 && out_exp == '0));

    // R7: no strobe means the data was held.
    p_hold_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arm2_q && !out_valid) |-> ($stable(out_mant) && $stable(out_exp)));

endmodule

bind adc_gate_front fe_gate_checker #(
    .MANT_W (MANT_W),
    .EXP_W  (EXP_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_q    (mode_q),
    .sel_en    (sel_en),
    .out_mant  (out_mant),
    .out_exp   (out_exp),
    .out_valid (out_valid)
);

// File: tb/adc_gate_front_tb.sv
module adc_gate_front_tb;

    localparam int MW = 5;
    localparam int EW = 2;
    localparam int DW = MW + EW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_port_sel = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic [MW-1:0] a_m = '0, b_m = '0;
    logic [EW-1:0] a_e = '0, b_e = '0;
    logic          a_en = 1'b0, b_en = 1'b0;
    logic [MW-1:0] out_mant;
    logic [EW-1:0] out_exp;
    logic          out_valid;

    int checks = 0;
    int errors = 0;

    // Reference state, derived from the requirements.
    logic          m_sel = 1'b0;
    logic [1:0]    m_mode = 2'd0;
    logic          m_prev = 1'b0;
    logic          m_hv = 1'b0;
    logic          e_valid = 1'b0;
    logic [MW-1:0] e_mant = '0;
    logic [EW-1:0] e_exp = '0;

    always #2 clk = ~clk;

    adc_gate_front #(.MANT_W(MW), .EXP_W(EW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_port_sel (cfg_port_sel),
        .cfg_mode     (cfg_mode),
        .port_a_mant  (a_m),
        .port_a_exp   (a_e),
        .port_a_en    (a_en),
        .port_b_mant  (b_m),
        .port_b_exp   (b_e),
        .port_b_en    (b_en),
        .out_mant     (out_mant),
        .out_exp      (out_exp),
        .out_valid    (out_valid)
    );

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual valid/mant/exp=%b expected=%b", req, act, exp);
        end
    endtask

    // One clock: predict the edge, let it happen, compare at the negedge (R10).
    task automatic tick(input string extra);
        logic se;
        logic [MW-1:0] sm;
        logic [EW-1:0] sx;
        logic acc;
        string req;
        se = m_sel ? b_en : a_en;
        sm = m_sel ? b_m  : a_m;
        sx = m_sel ? b_e  : a_e;
        case (m_mode)
            2'd0: req = "R3 R7";
            2'd1: req = "R4 R7";
            2'd2: req = "R5 R7";
            default: req = "R6";
        endcase
        req = {req, " R2 R8 R10 ", extra};
        if (!rst_n) begin
            e_valid = 1'b0; e_mant = '0; e_exp = '0;
            m_sel = 1'b0; m_mode = 2'd0; m_prev = 1'b0; m_hv = 1'b0;
            req = "R1";
        end else begin
            case (m_mode)
                2'd0: acc = se;
                2'd1: acc = m_hv && m_prev && !se;
                2'd2: acc = m_hv && !m_prev && se;
                default: acc = 1'b1;
            endcase
            e_valid = acc;
            if (m_mode == 2'd3) begin
                e_mant = se ? sm : '0;
                e_exp  = se ? sx : '0;
            end else if (acc) begin
                e_mant = sm;
                e_exp  = sx;
            end
            if (cfg_port_sel != m_sel || cfg_mode != m_mode) begin
                m_sel = cfg_port_sel; m_mode = cfg_mode; m_hv = 1'b0;
            end else begin
                m_prev = se; m_hv = 1'b1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(req, {out_valid, out_mant, out_exp}, {e_valid, e_mant, e_exp});
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state.
        @(negedge clk);
        tick("");
        tick("");
        rst_n = 1'b1;

        // Exhaustive sample sweep for every port and mode (R2..R8, R10).
        for (int p = 0; p < 2; p++) begin
            for (int md = 0; md < 4; md++) begin
                cfg_port_sel = p[0];
                cfg_mode = md[1:0];
                for (int i = 0; i < (1 << DW); i++) begin
                    logic [DW-1:0] code;
                    logic en_sel;
                    code = DW'(i);
                    en_sel = (i < 64) ? ((i % 5) < 2) : ((i % 3) == 0);
                    if (p == 0) begin
                        {a_m, a_e} = code; a_en = en_sel;
                        {b_m, b_e} = ~code; b_en = code[0];
                    end else begin
                        {b_m, b_e} = code; b_en = en_sel;
                        {a_m, a_e} = ~code; a_en = code[0];
                    end
                    tick("");
                end
            end
        end

        // R9: rising-edge mode, change port exactly when B's enable rises.
        cfg_port_sel = 1'b0; cfg_mode = 2'd2;
        a_en = 1'b0; b_en = 1'b0; a_m = 5'd3; b_m = 5'd9; a_e = 2'd1; b_e = 2'd2;
        for (int k = 0; k < 3; k++) tick("R9");
        cfg_port_sel = 1'b1;
        tick("R9");
        b_en = 1'b1;
        tick("R9");
        b_en = 1'b0;
        tick("R9");
        b_en = 1'b1;
        tick("R9");
        // R9: mode change to falling edge as enable drops.
        cfg_mode = 2'd1;
        tick("R9");
        b_en = 1'b0;
        tick("R9");
        tick("R9");

        // R1: reset in the middle of traffic.
        cfg_mode = 2'd3; b_en = 1'b1;
        tick("");
        tick("");
        rst_n = 1'b0;
        tick("");
        rst_n = 1'b1;
        tick("R1");
        tick("R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule